// File: doc/BRIEF.md
# Step Attenuator Programming Sequencer

This block sits on the host side of a six-bit digital step attenuator. It takes a requested attenuation code through a valid/ready handshake and turns it into pin waveforms for the attenuator's control interface. Two waveform styles are produced by one sequencer. In serial style the code is clocked out on a data line and a clock line and then committed by a latch-enable pulse. In latched parallel style the code is placed on six data lines and then committed by a latch-enable pulse. The configuration input `cfg_serial` picks the style. It is sampled only in the cycle a request is accepted.

Every pin interval is a parameter counted in system-clock cycles. The integrator rounds each nanosecond limit up to whole cycles. The defaults suit a 100 MHz clock. The block also spaces successive latch pulses by a minimum number of cycles, which caps how often the attenuator's state may change. A request is accepted only when `req_valid` and `req_ready` are both high on a rising clock edge. While `req_ready` is low the requester must hold its request, and it is back-pressured for the whole transfer and for the remainder of the spacing interval. A request equal to the previous code is sent again like any other. Code bit 5 carries the largest weight (16 dB) and bit 0 the smallest (0.5 dB).

Top module: `atten_prog_master`

## Requirements
- R1: In serial style, exactly six clock pulses are sent per transfer. The code is sent most significant bit first, so bit 5 is sampled on the first rising edge of `ser_clk` and bit 0 on the sixth.
- R2: `ser_clk` idles low. Each high phase lasts exactly CLK_HIGH_CYC cycles, and each low phase before a rising edge lasts at least CLK_LOW_CYC cycles.
- R3: `ser_data` changes only while `ser_clk` is low. It is stable for at least CLK_LOW_CYC cycles before each rising edge and for the whole high phase after it.
- R4: In serial style, `latch_en` is low while shifting and is never high together with `ser_clk`. It rises no sooner than CLK_HIGH_CYC + LE_SETUP_CYC cycles after the last rising edge of `ser_clk` and stays high for exactly SER_LE_PULSE_CYC cycles.
- R5: In latched parallel style, `par_data` shows the code at least PAR_SETUP_CYC cycles before `latch_en` rises. `latch_en` stays high for exactly PAR_LE_PULSE_CYC cycles, `par_data` is stable while `latch_en` is high, and `par_data` holds for at least HOLD_CYC cycles after the fall. No `ser_clk` pulse occurs in this style.
- R6: Successive rising edges of `latch_en` are at least MIN_GAP_CYC cycles apart.
- R7: `req_ready` is low from the accepting edge until MIN_GAP_CYC-1 cycles after the rising edge of `latch_en`. It is high exactly from then on while no request is accepted.
- R8: `done` is high for one cycle, in the same cycle that `latch_en` returns low, and at no other time.
- R9: The style is taken from `cfg_serial` at acceptance. Changing `cfg_serial` during a transfer does not change that transfer's waveform.
- R10: Every accepted request, including one that repeats the previous code, produces exactly one `latch_en` pulse and one `done` pulse.
- R11: After reset, `ser_clk`, `ser_data`, `latch_en`, `done` and `par_data` are all low and `req_ready` is high.
- R12: Outputs not used by a transfer keep their previous value. `par_data` does not change during a serial transfer, `ser_data` does not change during a parallel transfer, and after a serial transfer `ser_data` stays at code bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_serial | input | 1 | 1 selects serial style, 0 selects latched parallel style; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_code | input | CODE_W | Requested attenuation code, bit 5 = 16 dB |
| req_ready | output | 1 | Sequencer can accept a request |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock line |
| latch_en | output | 1 | Latch enable shared by both styles |
| par_data | output | CODE_W | Parallel data lines |
| done | output | 1 | One-cycle pulse when the latch enable falls |

## Verification
The hardest case to reach is a change of `cfg_serial` while a transfer is running, combined with a repeated code. If the style were not captured at acceptance, or a repeat were silently dropped, the pins would show a short or missing sequence that a plain request stream never exposes. The stimulus sends a code, flips `cfg_serial` a few cycles after acceptance, and then resends the same value. It also mixes directed single-bit and all-ones codes with seeded random codes and styles. A pin monitor rebuilds each shifted word and times every phase against the parameters.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SER_LOW,
    ST_SER_HIGH,
    ST_LE_WAIT,
    ST_PAR_SETUP,
    ST_LE_HIGH,
    ST_TAIL
  } seq_state_e;
endpackage

// File: rtl/atten_prog_timer.sv
// Down-counter: load N-1 on phase entry, expired marks the phase's last cycle.
module atten_prog_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/atten_prog_shreg.sv
// Left-shifting word register; its top bit drives the serial data line.
module atten_prog_shreg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word <= '0;
    else if (load)   word <= din;
    else if (shift)  word <= {word[W-2:0], 1'b0};
  end

  assign msb = word[W-1];
endmodule

// File: rtl/atten_prog_master.sv
module atten_prog_master
  import atten_prog_pkg::*;
#(
  parameter int CODE_W           = 6,
  parameter int CLK_LOW_CYC      = 5,
  parameter int CLK_HIGH_CYC     = 5,
  parameter int LE_SETUP_CYC     = 1,
  parameter int SER_LE_PULSE_CYC = 3,
  parameter int PAR_SETUP_CYC    = 1,
  parameter int PAR_LE_PULSE_CYC = 1,
  parameter int HOLD_CYC         = 1,
  parameter int MIN_GAP_CYC      = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_serial,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  output logic              req_ready,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              latch_en,
  output logic [CODE_W-1:0] par_data,
  output logic              done
);
  localparam int PH_A   = (CLK_LOW_CYC > CLK_HIGH_CYC) ? CLK_LOW_CYC : CLK_HIGH_CYC;
  localparam int PH_B   = (SER_LE_PULSE_CYC > PAR_LE_PULSE_CYC) ? SER_LE_PULSE_CYC : PAR_LE_PULSE_CYC;
  localparam int PH_C   = (LE_SETUP_CYC > PAR_SETUP_CYC) ? LE_SETUP_CYC : PAR_SETUP_CYC;
  localparam int PH_D   = (PH_A > PH_B) ? PH_A : PH_B;
  localparam int PH_E   = (PH_C > HOLD_CYC) ? PH_C : HOLD_CYC;
  localparam int PH_MAX = (PH_D > PH_E) ? PH_D : PH_E;
  localparam int TW     = $clog2(PH_MAX + 1);
  localparam int GW     = $clog2(MIN_GAP_CYC + 1);
  localparam int BW     = $clog2(CODE_W);

  seq_state_e     state, nxt;
  logic           ph_load, ph_done;
  logic [TW-1:0]  ph_val;
  logic           sh_load, sh_shift;
  logic           gap_start, gap_clear;
  logic [BW-1:0]  bit_idx;
  logic           accept;

  assign req_ready = (state == ST_IDLE) && gap_clear;
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt       = state;
    ph_load   = 1'b0;
    ph_val    = '0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    gap_start = 1'b0;
    case (state)
      ST_IDLE: if (accept) begin
        ph_load = 1'b1;
        if (cfg_serial) begin
          nxt     = ST_SER_LOW;
          ph_val  = TW'(CLK_LOW_CYC - 1);
          sh_load = 1'b1;
        end else begin
          nxt    = ST_PAR_SETUP;
          ph_val = TW'(PAR_SETUP_CYC - 1);
        end
      end
      ST_SER_LOW: if (ph_done) begin
        nxt     = ST_SER_HIGH;
        ph_load = 1'b1;
        ph_val  = TW'(CLK_HIGH_CYC - 1);
      end
      ST_SER_HIGH: if (ph_done) begin
        ph_load = 1'b1;
        if (bit_idx == '0) begin
          nxt    = ST_LE_WAIT;
          ph_val = TW'(LE_SETUP_CYC - 1);
        end else begin
          nxt      = ST_SER_LOW;
          ph_val   = TW'(CLK_LOW_CYC - 1);
          sh_shift = 1'b1;
        end
      end
      ST_LE_WAIT: if (ph_done) begin
        nxt       = ST_LE_HIGH;
        ph_load   = 1'b1;
        ph_val    = TW'(SER_LE_PULSE_CYC - 1);
        gap_start = 1'b1;
      end
      ST_PAR_SETUP: if (ph_done) begin
        nxt       = ST_LE_HIGH;
        ph_load   = 1'b1;
        ph_val    = TW'(PAR_LE_PULSE_CYC - 1);
        gap_start = 1'b1;
      end
      ST_LE_HIGH: if (ph_done) begin
        nxt     = ST_TAIL;
        ph_load = 1'b1;
        ph_val  = TW'(HOLD_CYC - 1);
      end
      ST_TAIL: if (ph_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ser_clk  <= 1'b0;
      latch_en <= 1'b0;
      done     <= 1'b0;
      par_data <= '0;
      bit_idx  <= '0;
    end else begin
      state    <= nxt;
      ser_clk  <= (nxt == ST_SER_HIGH);
      latch_en <= (nxt == ST_LE_HIGH);
      done     <= (state == ST_LE_HIGH) && (nxt == ST_TAIL);
      if (accept && !cfg_serial) par_data <= req_code;
      if (sh_load)               bit_idx  <= BW'(CODE_W - 1);
      else if (sh_shift)         bit_idx  <= bit_idx - 1'b1;
    end
  end

  atten_prog_timer #(.W(TW)) u_phase_timer (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .expired(ph_done)
  );

  atten_prog_timer #(.W(GW)) u_gap_timer (
    .clk(clk), .rst_n(rst_n), .load(gap_start), .load_val(GW'(MIN_GAP_CYC - 1)),
    .expired(gap_clear)
  );

  atten_prog_shreg #(.W(CODE_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(req_code), .shift(sh_shift),
    .msb(ser_data)
  );
endmodule

// File: rtl/atten_prog_checks.sv
module atten_prog_checks #(
  parameter int CODE_W      = 6,
  parameter int MIN_GAP_CYC = 4000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ser_data,
  input logic              ser_clk,
  input logic              latch_en,
  input logic [CODE_W-1:0] par_data,
  input logic              done
);
  localparam int GW = $clog2(MIN_GAP_CYC + 1) + 1;

  logic          le_q;
  logic [GW-1:0] since_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_q       <= 1'b0;
      since_rise <= GW'(MIN_GAP_CYC);
    end else begin
      le_q <= latch_en;
      if (latch_en && !le_q)                   since_rise <= '0;
      else if (since_rise < GW'(MIN_GAP_CYC))  since_rise <= since_rise + 1'b1;
    end
  end

  assert_clk_le_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_clk && latch_en));

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  assert_par_stable_le_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> $stable(par_data));

  assert_done_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(latch_en));

  assert_fall_gives_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_en) |-> done);

  assert_le_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && !le_q) |-> (since_rise >= GW'(MIN_GAP_CYC - 1)));

  assert_ready_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (since_rise >= GW'(MIN_GAP_CYC - 2)));
endmodule

bind atten_prog_master atten_prog_checks #(
  .CODE_W(CODE_W), .MIN_GAP_CYC(MIN_GAP_CYC)
) u_checks (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ser_data(ser_data),
  .ser_clk(ser_clk), .latch_en(latch_en), .par_data(par_data), .done(done)
);

// File: tb/atten_prog_master_bench.sv
module atten_prog_master_bench;
  localparam int LOW_C  = 7;
  localparam int HIGH_C = 7;
  localparam int LESU_C = 2;
  localparam int SPUL_C = 4;
  localparam int PSU_C  = 2;
  localparam int PPUL_C = 2;
  localparam int HOLD_C = 2;
  localparam int GAP_C  = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_serial = 1'b0;
  logic       req_valid = 1'b0;
  logic [5:0] req_code = '0;
  logic       req_ready, ser_data, ser_clk, latch_en, done;
  logic [5:0] par_data;

  always #4 clk = ~clk;

  atten_prog_master #(
    .CODE_W(6), .CLK_LOW_CYC(LOW_C), .CLK_HIGH_CYC(HIGH_C), .LE_SETUP_CYC(LESU_C),
    .SER_LE_PULSE_CYC(SPUL_C), .PAR_SETUP_CYC(PSU_C), .PAR_LE_PULSE_CYC(PPUL_C),
    .HOLD_CYC(HOLD_C), .MIN_GAP_CYC(GAP_C)
  ) u_atten_prog_master (
    .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .req_valid(req_valid),
    .req_code(req_code), .req_ready(req_ready), .ser_data(ser_data), .ser_clk(ser_clk),
    .latch_en(latch_en), .par_data(par_data), .done(done)
  );

  int n_checks = 0, n_fail = 0, n_sent = 0, n_done = 0, n_le = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int le_pulse_len(input bit ser);
    return ser ? SPUL_C : PPUL_C;
  endfunction

  // pin monitor
  logic       p_sclk = 0, p_le = 0, p_sdata = 0;
  logic [5:0] p_par = '0;
  bit         in_xfer = 0, exp_ser = 0, seen_le = 0;
  logic [5:0] exp_code = '0, word = '0;
  int nbits = 0, hi_len = 0, lo_len = 0, le_len = 0;
  int s_sdata = 0, s_srise = 1000000, s_lerise = 1000000, s_lefall = 1000000, s_par = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit sr = ser_clk && !p_sclk;
      automatic bit sf = !ser_clk && p_sclk;
      automatic bit lr = latch_en && !p_le;
      automatic bit lf = !latch_en && p_le;
      automatic bit dchg = (ser_data != p_sdata);
      automatic bit pchg = (par_data != p_par);

      s_sdata = dchg ? 0 : s_sdata + 1;
      s_srise = sr ? 0 : (s_srise < 1000000 ? s_srise + 1 : s_srise);
      s_par   = pchg ? 0 : s_par + 1;

      if (dchg) check(!ser_clk, "R3 data changed while clock high", ser_clk, 0);
      if (pchg) check(s_lefall + 1 >= HOLD_C, "R5 parallel hold after latch", s_lefall + 1, HOLD_C);
      if (in_xfer && exp_ser && pchg) check(0, "R12 par_data moved in serial transfer", par_data, p_par);
      if (in_xfer && !exp_ser && dchg) check(0, "R12 ser_data moved in parallel transfer", ser_data, p_sdata);
      if (in_xfer && !exp_ser && sr) check(0, "R5 serial clock in parallel style", 1, 0);

      if (ser_clk) hi_len++;
      else if (in_xfer) lo_len++;
      if (sr) begin
        check(lo_len >= LOW_C, "R2 clock low phase", lo_len, LOW_C);
        check(s_sdata >= LOW_C, "R3 data setup before rise", s_sdata, LOW_C);
        word = {word[4:0], ser_data};
        nbits++;
        lo_len = 0;
      end
      if (sf) begin
        check(hi_len == HIGH_C, "R2 clock high phase", hi_len, HIGH_C);
        hi_len = 0;
      end

      if (latch_en) le_len++;
      if (lr) begin
        n_le++;
        check(!ser_clk, "R4 latch with clock low", ser_clk, 0);
        if (seen_le) check(s_lerise + 1 >= GAP_C, "R6 latch spacing", s_lerise + 1, GAP_C);
        seen_le = 1;
        if (exp_ser) begin
          check(nbits == 6, "R1 serial pulse count", nbits, 6);
          check(word == exp_code, "R1 shifted word MSB first", word, exp_code);
          check(s_srise >= HIGH_C + LESU_C, "R4 latch setup after last rise", s_srise, HIGH_C + LESU_C);
          check(ser_data == exp_code[0], "R12 ser_data rests at bit0", ser_data, exp_code[0]);
        end else begin
          check(nbits == 0, "R5 no clocks in parallel", nbits, 0);
          check(par_data == exp_code, "R5 parallel code", par_data, exp_code);
          check(s_par >= PSU_C, "R5 parallel setup", s_par, PSU_C);
        end
      end
      s_lerise = lr ? 0 : (s_lerise < 1000000 ? s_lerise + 1 : s_lerise);
      s_lefall = lf ? 0 : (s_lefall < 1000000 ? s_lefall + 1 : s_lefall);

      if (lf) begin
        check(le_len == le_pulse_len(exp_ser), "R4 R5 latch pulse width (R9 style)", le_len, le_pulse_len(exp_ser));
        le_len = 0;
        in_xfer = 0;
      end
      check(done == lf, "R8 done with latch fall", done, lf);
      if (done) n_done++;

      begin
        automatic bit er = !in_xfer && (s_lerise >= GAP_C - 1);
        check(req_ready == er, "R7 ready timing", req_ready, er);
      end

      if (req_valid && req_ready) begin
        in_xfer = 1; exp_ser = cfg_serial; exp_code = req_code;
        nbits = 0; word = '0; lo_len = 0;
      end

      p_sclk = ser_clk; p_le = latch_en; p_sdata = ser_data; p_par = par_data;
    end
  end

  task automatic send(input logic [5:0] code, input bit ser, input bit flip);
    @(posedge clk); #2;
    cfg_serial = ser; req_code = code; req_valid = 1'b1;
    forever begin
      if (req_ready) begin
        @(posedge clk); #2;
        req_valid = 1'b0;
        break;
      end
      @(posedge clk); #2;
    end
    n_sent++;
    if (flip) begin
      repeat (5) @(posedge clk);
      #2 cfg_serial = ~cfg_serial;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd2468));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(ser_clk == 0 && ser_data == 0 && latch_en == 0 && done == 0,
          "R11 serial pins after reset", {ser_clk, ser_data, latch_en, done}, 0);
    check(par_data == 0, "R11 par_data after reset", par_data, 0);
    check(req_ready == 1, "R11 ready after reset", req_ready, 1);
    rst_n = 1'b1;

    send(6'b100000, 1, 0);       // R1 only top bit
    send(6'b000001, 1, 0);       // R1 only bottom bit
    send(6'b111111, 0, 0);       // R5 all ones
    send(6'b111111, 0, 1);       // R10 repeat, R9 flip to serial mid-transfer
    send(6'b010101, 1, 1);       // R9 flip to parallel mid-transfer
    send(6'b010101, 1, 0);       // R10 repeat serial
    for (int i = 0; i < 16; i++)
      send(6'($urandom_range(0, 63)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));

    while (!req_ready) @(posedge clk);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(n_done == n_sent, "R10 one done per request", n_done, n_sent);
    check(n_le == n_sent, "R10 one latch per request", n_le, n_sent);
    check(ser_clk == 0 && latch_en == 0, "R2 R4 idle levels", {ser_clk, latch_en}, 0);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule